// File: doc/BRIEF.md
# Locked Index/Data Watchdog Controller

A byte-wide register port pair (one index port, one data port) gives access to a small countdown watchdog. The watchdog registers stay closed until the same magic code is written twice in a row to the index port. After that, a page-select write must choose the watchdog control page. A separate close code written to the index port locks the registers again and drops the page selection.

Once configured, the watchdog counts down an 8-bit value. Each step is either one seconds tick or sixty of them, depending on the unit select. When the count steps from 1 to 0 while the watchdog is enabled, the block raises a one-cycle reset request. Keyboard or mouse interrupt pulses can reload the last programmed value, and each of these sources has its own enable. The seconds tick comes from a prescaler outside this block.

Top module: `wdt_portctl`

## Requirements
- R1: Two consecutive index-port writes of 0x87 open configuration mode. Any other index value written after a single 0x87 discards the progress, so one 0x87 alone never opens the registers.
- R2: While the block is locked, or while the watchdog page is not selected, data-port writes to watchdog registers change nothing and data-port reads return 0xFF. While locked, index-port reads also return 0xFF.
- R3: When open, an index write of 0x07 followed by a data write of 0x08 selects the watchdog page, and a data read at index 0x07 returns the selected page. An index write of 0xAA locks the block and clears the page selection.
- R4: Register 0x30 bit 0 is the enable (1 = run). While it is 0, seconds ticks leave the count unchanged.
- R5: Register 0xF5 bit 3 selects the unit: 0 means every seconds tick decrements, and 1 means every 60th tick decrements.
- R6: A write to register 0xF6 loads the count and also stores it as the reload value. A read of 0xF6 returns the live remaining count.
- R7: In register 0xF7, bit 6 lets a keyboard interrupt pulse reload the count with the stored reload value, and bit 7 does the same for mouse pulses. With a bit clear, that source's pulses have no effect.
- R8: The reset request is registered and lasts one cycle. It appears on the clock edge at which an enabled count goes from 1 to 0, and the count then stays at 0.
- R9: When events coincide in one cycle, a 0xF6 data write beats an interrupt reload, and an interrupt reload beats a decrement. A beaten decrement raises no reset request.
- R10: After reset the block is locked, no page is selected, all registers and the count are 0, and the reset request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the port pair |
| bus_rd | input | 1 | Read strobe for the port pair |
| bus_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after bus_rd |
| sec_tick | input | 1 | One-cycle seconds tick |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| ms_irq | input | 1 | Mouse interrupt pulse |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two collisions are checked. In the first, the terminal seconds tick (count at 1) and an enabled keyboard pulse arrive in the same cycle. In the second, the terminal tick and a data write to the count register arrive in the same cycle. The bench raises both inputs in the same clock cycle. It then judges two things: that the reset request stays low, and that the count read back afterwards equals the reload value in the first case and the written value in the second.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] K_OPEN     = 8'h87;
  localparam logic [DW-1:0] K_CLOSE    = 8'hAA;
  localparam logic [DW-1:0] K_PAGE_IDX = 8'h07;
  localparam logic [DW-1:0] K_WDT_PAGE = 8'h08;
  localparam logic [DW-1:0] A_ENABLE   = 8'h30;
  localparam logic [DW-1:0] A_UNIT     = 8'hF5;
  localparam logic [DW-1:0] A_COUNT    = 8'hF6;
  localparam logic [DW-1:0] A_SOURCE   = 8'hF7;

  typedef enum logic [1:0] {
    GS_LOCKED = 2'd0,
    GS_HALF   = 2'd1,
    GS_OPEN   = 2'd2
  } gate_state_e;
endpackage

// File: rtl/wdt_gate.sv
module wdt_gate
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_we,
  input  logic          dat_we,
  input  logic [DW-1:0] wdata,
  output logic          is_open,
  output logic          page_ok,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] page_q
);
  gate_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= GS_LOCKED;
      idx_q  <= '0;
      page_q <= '0;
    end else begin
      if (idx_we) begin
        case (state)
          GS_LOCKED: if (wdata == K_OPEN) state <= GS_HALF;
          GS_HALF:   state <= (wdata == K_OPEN) ? GS_OPEN : GS_LOCKED;
          default: begin
            if (wdata == K_CLOSE) begin
              state  <= GS_LOCKED;
              page_q <= '0;
            end else begin
              idx_q <= wdata;
            end
          end
        endcase
      end else if (dat_we && state == GS_OPEN && idx_q == K_PAGE_IDX) begin
        page_q <= wdata;
      end
    end
  end

  assign is_open = (state == GS_OPEN);
  assign page_ok = is_open && (page_q == K_WDT_PAGE);

  // R1
  open_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (state == GS_LOCKED) |=> (state != GS_OPEN));
  // R3
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_we && is_open && wdata == K_CLOSE) |=> (!is_open && !page_ok));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          en,
  output logic          unit_min,
  output logic          kbd_en,
  output logic          ms_en,
  output logic          cnt_we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      unit_min <= 1'b0;
      kbd_en   <= 1'b0;
      ms_en    <= 1'b0;
    end else if (we) begin
      case (addr)
        A_ENABLE: en       <= wdata[0];
        A_UNIT:   unit_min <= wdata[3];
        A_SOURCE: begin
          kbd_en <= wdata[6];
          ms_en  <= wdata[7];
        end
        default: ;
      endcase
    end
  end

  assign cnt_we = we && (addr == A_COUNT);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable({en, unit_min, kbd_en, ms_en}));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW      = 8,
  parameter int MIN_DIV = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          unit_min,
  input  logic          kbd_en,
  input  logic          ms_en,
  input  logic          kbd_irq,
  input  logic          ms_irq,
  input  logic          sec_tick,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt,
  output logic          rst_req
);
  localparam int PW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(MIN_DIV - 1);

  logic [PW-1:0] presc;
  logic [CW-1:0] rel;
  logic          irq_ld;
  logic          stepping;

  assign irq_ld   = (kbd_en && kbd_irq) || (ms_en && ms_irq);
  assign stepping = en && sec_tick && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rel     <= '0;
      presc   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (ld) begin
        cnt   <= ld_val;
        rel   <= ld_val;
        presc <= '0;
      end else if (irq_ld) begin
        cnt   <= rel;
        presc <= '0;
      end else if (stepping) begin
        if (unit_min && presc != P_LAST) begin
          presc <= presc + 1'b1;
        end else begin
          presc   <= '0;
          cnt     <= cnt - 1'b1;
          rst_req <= (cnt == CW'(1));
        end
      end
    end
  end

  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R8
  req_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (cnt == '0));
  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld && !irq_ld) |=> $stable(cnt));
  // R5
  presc_range_chk: assert property (@(posedge clk) disable iff (rst)
    presc <= P_LAST);
endmodule

// File: rtl/wdt_portctl.sv
module wdt_portctl
  import wdt_pkg::*;
#(
  parameter int MIN_DIV = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_sel_data,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sec_tick,
  input  logic          kbd_irq,
  input  logic          ms_irq,
  output logic          rst_req
);
  logic          is_open, page_ok, en, unit_min, kbd_en, ms_en, cnt_we;
  logic [DW-1:0] idx_q, page_q, cnt, rd_val;
  logic          idx_we, dat_we;

  assign idx_we = bus_wr && !bus_sel_data;
  assign dat_we = bus_wr && bus_sel_data;

  wdt_gate u_gate (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .wdata(bus_wdata),
    .is_open(is_open), .page_ok(page_ok), .idx_q(idx_q), .page_q(page_q)
  );

  wdt_cfg u_cfg (
    .clk(clk), .rst(rst), .we(dat_we && page_ok), .addr(idx_q), .wdata(bus_wdata),
    .en(en), .unit_min(unit_min), .kbd_en(kbd_en), .ms_en(ms_en), .cnt_we(cnt_we)
  );

  wdt_count #(.CW(DW), .MIN_DIV(MIN_DIV)) u_count (
    .clk(clk), .rst(rst), .en(en), .unit_min(unit_min), .kbd_en(kbd_en),
    .ms_en(ms_en), .kbd_irq(kbd_irq), .ms_irq(ms_irq), .sec_tick(sec_tick),
    .ld(cnt_we), .ld_val(bus_wdata), .cnt(cnt), .rst_req(rst_req)
  );

  always_comb begin
    rd_val = '1;
    if (is_open) begin
      if (!bus_sel_data)                rd_val = idx_q;
      else if (idx_q == K_PAGE_IDX)     rd_val = page_q;
      else if (page_ok) begin
        case (idx_q)
          A_ENABLE: rd_val = {7'b0, en};
          A_UNIT:   rd_val = {4'b0, unit_min, 3'b0};
          A_COUNT:  rd_val = cnt;
          A_SOURCE: rd_val = {ms_en, kbd_en, 6'b0};
          default:  rd_val = '1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '1;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !is_open) |=> (bus_rdata == '1));
endmodule

// File: tb/wdt_portctl_test.sv
`timescale 1ns/1ps
module wdt_portctl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_data = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sec_tick = 1'b0, kbd_irq = 1'b0, ms_irq = 1'b0;
  logic       rst_req;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_portctl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_tick(sec_tick), .kbd_irq(kbd_irq), .ms_irq(ms_irq), .rst_req(rst_req)
  );

  // kind: 0 index write, 1 data write, 2 data read (compare)
  localparam int NV = 32;
  localparam logic [17:0] VEC [NV] = '{
    {2'd2, 8'h00, 8'hFF},  // R2 locked read
    {2'd0, 8'h87, 8'h00},
    {2'd0, 8'h12, 8'h00},  // R1 breaks progress
    {2'd0, 8'h87, 8'h00},
    {2'd0, 8'h07, 8'h00},  // R1 single code then other -> locked
    {2'd1, 8'h08, 8'h00},  // R2 ignored while locked
    {2'd0, 8'h87, 8'h00},
    {2'd0, 8'h87, 8'h00},  // R1 open
    {2'd0, 8'hF6, 8'h00},
    {2'd1, 8'h33, 8'h00},  // R2 no page: ignored
    {2'd2, 8'h00, 8'hFF},  // R2 no page read
    {2'd0, 8'h07, 8'h00},
    {2'd1, 8'h08, 8'h00},  // R3 page select
    {2'd2, 8'h00, 8'h08},  // R3 page readback
    {2'd0, 8'hF6, 8'h00},
    {2'd2, 8'h00, 8'h00},  // R2 earlier write had no effect
    {2'd1, 8'h33, 8'h00},
    {2'd2, 8'h00, 8'h33},  // R6
    {2'd0, 8'hF5, 8'h00},
    {2'd1, 8'h08, 8'h00},
    {2'd2, 8'h00, 8'h08},  // R5 field
    {2'd0, 8'hF7, 8'h00},
    {2'd1, 8'hC0, 8'h00},
    {2'd2, 8'h00, 8'hC0},  // R7 fields
    {2'd0, 8'h30, 8'h00},
    {2'd2, 8'h00, 8'h00},  // R4 enable off
    {2'd0, 8'hAA, 8'h00},  // R3 relock
    {2'd2, 8'h00, 8'hFF},  // R3 locked again
    {2'd0, 8'h87, 8'h00},
    {2'd0, 8'h87, 8'h00},
    {2'd0, 8'h30, 8'h00},
    {2'd2, 8'h00, 8'hFF}   // R3 page cleared by relock
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input bit wr, input bit sel, input logic [7:0] v);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_sel_data = sel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
    bus_op(1'b1, 1'b0, a);
    bus_op(1'b1, 1'b1, v);
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
    bus_op(1'b1, 1'b0, a);
    bus_op(1'b0, 1'b1, 8'h00);
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic open_page();
    bus_op(1'b1, 1'b0, 8'h87);
    bus_op(1'b1, 1'b0, 8'h87);
    wr_reg(8'h07, 8'h08);
  endtask

  task automatic tick(input bit exp_req, input string req);
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(rst_req == exp_req, req, rst_req, exp_req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    check(rst_req == 1'b0, "R10 rst_req", rst_req, 0);
    check(bus_rdata == 8'hFF, "R10 rdata", bus_rdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17:16] == 2'd2) begin
        bus_op(1'b0, 1'b1, 8'h00);
        check(bus_rdata == VEC[i][7:0], $sformatf("R2/R3 table vec %0d", i),
              bus_rdata, VEC[i][7:0]);
      end else begin
        bus_op(1'b1, VEC[i][17:16] == 2'd1, VEC[i][15:8]);
      end
    end

    // R10 registers cleared by reset
    do_reset();
    open_page();
    rd_reg(8'hF6, 8'h00, "R10 count");
    rd_reg(8'hF7, 8'h00, "R10 source");

    // R4, R6, R8 seconds countdown
    wr_reg(8'hF6, 8'h03);
    rd_reg(8'hF6, 8'h03, "R6 load");
    tick(1'b0, "R4 disabled tick");
    rd_reg(8'hF6, 8'h03, "R4 hold while off");
    wr_reg(8'h30, 8'h01);
    rd_reg(8'h30, 8'h01, "R4 enable bit");
    tick(1'b0, "R8 no early req");
    rd_reg(8'hF6, 8'h02, "R6 live count");
    tick(1'b0, "R8 no early req");
    tick(1'b1, "R8 req on 1->0");
    @(negedge clk);
    check(rst_req == 1'b0, "R8 one cycle", rst_req, 0);
    rd_reg(8'hF6, 8'h00, "R8 stays 0");
    tick(1'b0, "R8 no repeat at 0");

    // R5 minutes
    wr_reg(8'hF5, 8'h08);
    wr_reg(8'hF6, 8'h02);
    for (int k = 0; k < 59; k++) tick(1'b0, "R5 minute tick");
    rd_reg(8'hF6, 8'h02, "R5 59 ticks");
    tick(1'b0, "R5 60th tick");
    rd_reg(8'hF6, 8'h01, "R5 after 60");

    // R7 reload sources
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF7, 8'h40);
    wr_reg(8'hF6, 8'h05);
    tick(1'b0, "R7 tick"); tick(1'b0, "R7 tick");
    @(negedge clk); ms_irq = 1'b1; @(negedge clk); ms_irq = 1'b0;
    rd_reg(8'hF6, 8'h03, "R7 mouse disabled");
    @(negedge clk); kbd_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0;
    rd_reg(8'hF6, 8'h05, "R7 keyboard reload");
    wr_reg(8'hF7, 8'h80);
    tick(1'b0, "R7 tick");
    @(negedge clk); ms_irq = 1'b1; @(negedge clk); ms_irq = 1'b0;
    rd_reg(8'hF6, 8'h05, "R7 mouse reload");

    // R9 coincidences
    wr_reg(8'hF7, 8'h40);
    wr_reg(8'hF6, 8'h04);
    tick(1'b0, "R9 setup"); tick(1'b0, "R9 setup"); tick(1'b0, "R9 setup");
    rd_reg(8'hF6, 8'h01, "R9 count at 1");
    @(negedge clk); sec_tick = 1'b1; kbd_irq = 1'b1;
    @(negedge clk); sec_tick = 1'b0; kbd_irq = 1'b0;
    check(rst_req == 1'b0, "R9 reload beats step", rst_req, 0);
    rd_reg(8'hF6, 8'h04, "R9 reload value");
    tick(1'b0, "R9 setup"); tick(1'b0, "R9 setup"); tick(1'b0, "R9 setup");
    @(negedge clk);
    sec_tick = 1'b1; bus_wr = 1'b1; bus_sel_data = 1'b1; bus_wdata = 8'h09;
    @(negedge clk);
    sec_tick = 1'b0; bus_wr = 1'b0;
    check(rst_req == 1'b0, "R9 write beats step", rst_req, 0);
    rd_reg(8'hF6, 8'h09, "R9 written value");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule